// File: doc/BRIEF.md
# Low-Power DMA Wakeup Controller

This block holds the power state of a device and decides how DMA trigger requests move it between states. There are four states it can leave on its own: active, a clock-gated sleep in which only DMA runs (LPM0), and two retained sleeps (LPM3 and LPM4). There are also two supply-off states (LPM3.5 and LPM4.5) that only a reset can leave. Software in active mode asks for a sleep state. Peripheral DMA channels and one external trigger pin then raise requests, and a wakeup-enable bit per source gates each request.

A request with its wakeup enabled pulls the device out of LPM3 or LPM4 into LPM0, never straight into active mode. The block remembers which retained sleep it left and holds the waking request for one cycle, so the DMA still sees it. The device then waits in LPM0 until a DMA-done or other interrupt makes it active. When interrupt service ends with the sleep-on-exit flag set, the block goes back to the remembered sleep. In active mode and in LPM0, requests go straight through to the DMA and the mode does not change.

Top module: `lpdw_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the mode to active (code 0). After reset, no resume memory and no held request remain.
- R2: Mode codes are: active=0, LPM0=1, LPM3=3, LPM4=4, LPM3.5=5, LPM4.5=6. `cpu_clk_en` is 1 only in active. `dma_run` is 1 only in active or LPM0.
- R3: In active mode, `sleep_req` moves the mode to `sleep_target` on the next edge if the target is 1, 3, 4, 5 or 6. Any other target code is ignored. Entering a sleep this way clears the resume memory.
- R4: In LPM3 or LPM4, a channel request `dma_req[i]` whose `wake_en[i]` is 1 moves the mode to LPM0 on the next edge and records the state it left. If `wake_en[i]` is 0, the request leaves the mode unchanged and nothing is forwarded.
- R5: The external request counts only while `ext_alt_fn` and `ext_dir_in` are both 1. It appears on `dma_fwd[NCH]`. Waking from LPM3 or LPM4 through it also needs `ext_wake_en`.
- R6: In LPM3.5 and LPM4.5, every input except reset is ignored: the mode holds and `dma_fwd` stays 0.
- R7: In active mode and in LPM0, each qualified request shows on `dma_fwd` in the same cycle, whatever its wake enable, and the mode does not change because of it.
- R8: The enabled requests that wake the block are held and driven on `dma_fwd` for exactly the first cycle after the wake.
- R9: LPM0 is kept until `dma_done` or `irq` is seen. Either one moves the mode to active on the next edge.
- R10: In active mode, `isr_done` with `sleep_on_exit` set and a remembered sleep returns the mode to that sleep (LPM3 or LPM4) and clears the memory. This takes priority over `sleep_req`. Without `sleep_on_exit`, `isr_done` leaves the mode active and keeps the memory.
- R11: `irq` in LPM3 or LPM4 moves the mode to active and clears the resume memory, and it wins over a same-cycle wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req | input | NCH | Peripheral DMA requests, one per channel |
| wake_en | input | NCH | Per-channel wakeup enable |
| ext_trig | input | 1 | External trigger pin level |
| ext_alt_fn | input | 1 | Pin is routed to its trigger function |
| ext_dir_in | input | 1 | Pin direction is input |
| ext_wake_en | input | 1 | Wakeup enable for the external trigger |
| dma_done | input | 1 | DMA completion interrupt |
| irq | input | 1 | Any other peripheral or pin interrupt |
| sleep_req | input | 1 | Software sleep request (active mode only) |
| sleep_target | input | 3 | Requested mode code |
| sleep_on_exit | input | 1 | Return to remembered sleep at end of service |
| isr_done | input | 1 | Pulse marking the end of interrupt service |
| pwr_mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_run | output | 1 | DMA engine enable |
| dma_fwd | output | NCH+1 | Requests passed to the DMA; top bit is the external pin |

## Verification
The bench runs a behavioural model alongside the design and compares the mode, both enables and the forwarded requests on every cycle. It goes after these corner cases:

- A request whose wake enable is clear arrives in a retained sleep. A design that woke on it would move to LPM0 early.
- The external pin is half-configured. A design that checked only one of its qualifiers would wake or forward on it.
- A wake request and `irq` arrive together. The wrong winner leaves stale resume memory behind.
- `isr_done` comes with no memory, or with the flag clear. Here a faulty design would drop into a sleep.
- The supply-off states receive every kind of stimulus, which must not release them.
- The cycle right after a wake is checked for the held request. A design that lost it would never start the transfer that caused the wakeup.

// File: rtl/lpdw_pkg.sv
package lpdw_pkg;

    typedef enum logic [2:0] {
        M_ACTIVE = 3'd0,
        M_LPM0   = 3'd1,
        M_LPM3   = 3'd3,
        M_LPM4   = 3'd4,
        M_LPM35  = 3'd5,
        M_LPM45  = 3'd6
    } pmode_e;

    typedef struct packed {
        logic trig;
        logic alt_fn;
        logic dir_in;
        logic wake_en;
    } ext_pin_t;

    typedef struct packed {
        logic       req;
        logic [2:0] target;
        logic       on_exit;
        logic       isr_done;
    } sleep_cmd_t;

    function automatic logic is_run(pmode_e m);
        return (m == M_ACTIVE) || (m == M_LPM0);
    endfunction

    function automatic logic is_retained(pmode_e m);
        return (m == M_LPM3) || (m == M_LPM4);
    endfunction

    function automatic logic is_off(pmode_e m);
        return (m == M_LPM35) || (m == M_LPM45);
    endfunction

    function automatic logic target_ok(logic [2:0] c);
        return (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5) || (c == 3'd6);
    endfunction

endpackage

// File: rtl/lpdw_trig_qual.sv
module lpdw_trig_qual
    import lpdw_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] dma_req,
    input  logic [NCH-1:0] wake_en,
    input  ext_pin_t       ext,
    output logic [NCH:0]   fwd_vec,
    output logic [NCH:0]   wake_vec
);
    localparam int EXT_IDX = NCH;

    logic ext_ok;
    assign ext_ok = ext.trig & ext.alt_fn & ext.dir_in;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign fwd_vec[i]  = dma_req[i];
        assign wake_vec[i] = dma_req[i] & wake_en[i];
    end

    assign fwd_vec[EXT_IDX]  = ext_ok;
    assign wake_vec[EXT_IDX] = ext_ok & ext.wake_en;

endmodule

// File: rtl/lpdw_mode_fsm.sv
module lpdw_mode_fsm
    import lpdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wake_any,
    input  logic       irq,
    input  logic       dma_done,
    input  sleep_cmd_t cmd,
    output pmode_e     mode
);
    pmode_e mode_q, mode_d;
    pmode_e res_q, res_d;
    logic   rv_q, rv_d;

    always_comb begin
        mode_d = mode_q;
        res_d  = res_q;
        rv_d   = rv_q;
        case (mode_q)
            M_ACTIVE: begin
                if (cmd.isr_done && cmd.on_exit && rv_q) begin
                    mode_d = res_q;
                    rv_d   = 1'b0;
                end else if (cmd.req && target_ok(cmd.target)) begin
                    mode_d = pmode_e'(cmd.target);
                    rv_d   = 1'b0;
                end
            end
            M_LPM0: begin
                if (irq || dma_done) mode_d = M_ACTIVE;
            end
            M_LPM3, M_LPM4: begin
                if (irq) begin
                    mode_d = M_ACTIVE;
                    rv_d   = 1'b0;
                end else if (wake_any) begin
                    res_d  = mode_q;
                    rv_d   = 1'b1;
                    mode_d = M_LPM0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_ACTIVE;
            res_q  <= M_LPM3;
            rv_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            res_q  <= res_d;
            rv_q   <= rv_d;
        end
    end

    assign mode = mode_q;

    a_r4_wake_to_lpm0: assert property (@(posedge clk) disable iff (rst)
        (is_retained(mode_q) && wake_any && !irq) |=> (mode_q == M_LPM0));

    a_r6_off_holds: assert property (@(posedge clk) disable iff (rst)
        is_off(mode_q) |=> (mode_q == $past(mode_q)));

    a_r9_lpm0_exit: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == M_LPM0) && (irq || dma_done)) |=> (mode_q == M_ACTIVE));

    a_r10_resume: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == M_ACTIVE) && cmd.isr_done && cmd.on_exit && rv_q)
        |=> (is_retained(mode_q) && !rv_q));

    a_r11_irq_wins: assert property (@(posedge clk) disable iff (rst)
        (is_retained(mode_q) && irq) |=> ((mode_q == M_ACTIVE) && !rv_q));

endmodule

// File: rtl/lpdw_fwd.sv
module lpdw_fwd
    import lpdw_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  pmode_e       mode,
    input  logic [W-1:0] fwd_vec,
    input  logic [W-1:0] wake_vec,
    output logic [W-1:0] dma_fwd
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= is_retained(mode) ? wake_vec : '0;
    end

    assign dma_fwd = is_run(mode) ? (fwd_vec | pend_q) : '0;

    a_r8_hold_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |=> (pend_q == '0));

    a_r6_off_no_hold: assert property (@(posedge clk) disable iff (rst)
        is_off(mode) |=> (pend_q == '0));

    a_r7_pass_through: assert property (@(posedge clk) disable iff (rst)
        is_run(mode) |-> ((dma_fwd & fwd_vec) == fwd_vec));

endmodule

// File: rtl/lpdw_ctrl.sv
module lpdw_ctrl
    import lpdw_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] dma_req,
    input  logic [NCH-1:0] wake_en,
    input  logic           ext_trig,
    input  logic           ext_alt_fn,
    input  logic           ext_dir_in,
    input  logic           ext_wake_en,
    input  logic           dma_done,
    input  logic           irq,
    input  logic           sleep_req,
    input  logic [2:0]     sleep_target,
    input  logic           sleep_on_exit,
    input  logic           isr_done,
    output logic [2:0]     pwr_mode,
    output logic           cpu_clk_en,
    output logic           dma_run,
    output logic [NCH:0]   dma_fwd
);
    localparam int W = NCH + 1;

    ext_pin_t     ext;
    sleep_cmd_t   cmd;
    logic [W-1:0] fwd_vec, wake_vec;
    pmode_e       mode;

    assign ext = '{trig: ext_trig, alt_fn: ext_alt_fn, dir_in: ext_dir_in, wake_en: ext_wake_en};
    assign cmd = '{req: sleep_req, target: sleep_target, on_exit: sleep_on_exit, isr_done: isr_done};

    lpdw_trig_qual #(.NCH(NCH)) u_qual (
        .dma_req (dma_req),
        .wake_en (wake_en),
        .ext     (ext),
        .fwd_vec (fwd_vec),
        .wake_vec(wake_vec)
    );

    lpdw_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wake_any(|wake_vec),
        .irq     (irq),
        .dma_done(dma_done),
        .cmd     (cmd),
        .mode    (mode)
    );

    lpdw_fwd #(.W(W)) u_fwd (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .fwd_vec (fwd_vec),
        .wake_vec(wake_vec),
        .dma_fwd (dma_fwd)
    );

    assign pwr_mode   = mode;
    assign cpu_clk_en = (mode == M_ACTIVE);
    assign dma_run    = is_run(mode);

    a_r2_gated_no_fwd: assert property (@(posedge clk) disable iff (rst)
        !dma_run |-> (dma_fwd == '0));

    a_r1_reset_active: assert property (@(posedge clk)
        rst |=> (pwr_mode == 3'd0));

endmodule

// File: tb/lpdw_ctrl_tb.sv
module lpdw_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] dma_req = '0, wake_en = '0;
    logic           ext_trig = 0, ext_alt_fn = 0, ext_dir_in = 0, ext_wake_en = 0;
    logic           dma_done = 0, irq = 0, sleep_req = 0, sleep_on_exit = 0, isr_done = 0;
    logic [2:0]     sleep_target = '0;
    logic [2:0]     pwr_mode;
    logic           cpu_clk_en, dma_run;
    logic [NCH:0]   dma_fwd;

    int checks = 0, failures = 0;
    bit finished = 0;

    int          m_mode, m_res;
    bit          m_rv;
    logic [NCH:0] m_pend;

    always #(CLK_P/2) clk = ~clk;

    lpdw_ctrl #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .dma_req(dma_req), .wake_en(wake_en),
        .ext_trig(ext_trig), .ext_alt_fn(ext_alt_fn), .ext_dir_in(ext_dir_in),
        .ext_wake_en(ext_wake_en), .dma_done(dma_done), .irq(irq),
        .sleep_req(sleep_req), .sleep_target(sleep_target),
        .sleep_on_exit(sleep_on_exit), .isr_done(isr_done),
        .pwr_mode(pwr_mode), .cpu_clk_en(cpu_clk_en), .dma_run(dma_run),
        .dma_fwd(dma_fwd)
    );

    function automatic logic [NCH:0] qual();
        return {ext_trig & ext_alt_fn & ext_dir_in, dma_req};
    endfunction

    function automatic logic [NCH:0] wakes();
        return qual() & {ext_wake_en, wake_en};
    endfunction

    task automatic clear_in();
        dma_req = '0; wake_en = '0; ext_trig = 0; ext_alt_fn = 0; ext_dir_in = 0;
        ext_wake_en = 0; dma_done = 0; irq = 0; sleep_req = 0; sleep_target = '0;
        sleep_on_exit = 0; isr_done = 0;
    endtask

    // Called just after a falling edge with inputs settled.
    task automatic step(input string tag);
        logic [NCH:0] e_fwd;
        bit run, good;
        #1;
        run   = (m_mode == 0) || (m_mode == 1);
        e_fwd = run ? (qual() | m_pend) : '0;
        good  = (int'(pwr_mode) == m_mode) && (cpu_clk_en == (m_mode == 0)) &&
                (dma_run == run) && (dma_fwd == e_fwd);
        if (!rst) begin
            checks++;
            if (!good) begin
                failures++;
                $display("FAIL %s mode=%0d/%0d cpu=%0b/%0b run=%0b/%0b fwd=%b/%b (actual/expected)",
                         tag, pwr_mode, m_mode, cpu_clk_en, m_mode == 0, dma_run, run, dma_fwd, e_fwd);
            end
        end
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_res = 3; m_rv = 0; m_pend = '0;
        end else begin
            logic [NCH:0] wk;
            int old;
            wk  = wakes();
            old = m_mode;
            case (m_mode)
                0: begin
                    if (isr_done && sleep_on_exit && m_rv) begin m_mode = m_res; m_rv = 0; end
                    else if (sleep_req && (sleep_target inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd6})) begin
                        m_mode = int'(sleep_target); m_rv = 0;
                    end
                end
                1: if (irq || dma_done) m_mode = 0;
                3, 4: begin
                    if (irq) begin m_mode = 0; m_rv = 0; end
                    else if (wk != '0) begin m_res = m_mode; m_rv = 1; m_mode = 1; end
                end
                default: ;
            endcase
            m_pend = (old == 3 || old == 4) ? wk : '0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin clear_in(); step(tag); end
    endtask

    task automatic go_sleep(input logic [2:0] t, input string tag);
        clear_in(); sleep_req = 1; sleep_target = t; step(tag);
    endtask

    task automatic do_reset();
        clear_in(); rst = 1; step("R1"); step("R1"); rst = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_res = 3; m_rv = 0; m_pend = '0;
        @(negedge clk);
        do_reset();
        idle(2, "R1");
        // R7 pass-through in active
        clear_in(); dma_req = 4'b0101; step("R7");
        clear_in(); ext_trig = 1; ext_alt_fn = 1; ext_dir_in = 1; step("R5");
        clear_in(); ext_trig = 1; ext_alt_fn = 0; ext_dir_in = 1; step("R5");
        // R3 bad targets then LPM3
        go_sleep(3'd2, "R3"); go_sleep(3'd7, "R3"); go_sleep(3'd3, "R3");
        idle(1, "R2");
        // R4 disabled wake
        clear_in(); dma_req = 4'b0010; wake_en = 4'b1101; step("R4");
        idle(1, "R4");
        clear_in(); dma_req = 4'b0010; wake_en = 4'b0010; step("R4");
        clear_in(); dma_req = 4'b1000; step("R8");
        idle(3, "R9");
        clear_in(); dma_done = 1; step("R9");
        // R10
        clear_in(); isr_done = 1; sleep_on_exit = 0; step("R10");
        clear_in(); isr_done = 1; sleep_on_exit = 1; sleep_req = 1; sleep_target = 3'd1; step("R10");
        clear_in(); isr_done = 1; sleep_on_exit = 1; step("R10");
        // R5 external pin wake qualification in LPM3
        clear_in(); ext_trig = 1; ext_alt_fn = 1; ext_dir_in = 0; ext_wake_en = 1; step("R5");
        clear_in(); ext_trig = 1; ext_alt_fn = 1; ext_dir_in = 1; ext_wake_en = 0; step("R5");
        clear_in(); ext_trig = 1; ext_alt_fn = 1; ext_dir_in = 1; ext_wake_en = 1; step("R5");
        idle(1, "R8");
        clear_in(); irq = 1; step("R9");
        clear_in(); isr_done = 1; sleep_on_exit = 1; step("R10");
        // R11 irq beats wake
        clear_in(); irq = 1; dma_req = 4'b0001; wake_en = 4'b0001; step("R11");
        idle(1, "R8");
        clear_in(); isr_done = 1; sleep_on_exit = 1; step("R11");
        go_sleep(3'd4, "R3");
        clear_in(); dma_req = 4'b0100; wake_en = 4'b0100; step("R4");
        idle(1, "R8");
        clear_in(); irq = 1; step("R9");
        clear_in(); isr_done = 1; sleep_on_exit = 1; step("R10");
        clear_in(); irq = 1; step("R11");
        // R6 supply-off states
        go_sleep(3'd5, "R3");
        for (int i = 0; i < 6; i++) begin
            dma_req = '1; wake_en = '1; ext_trig = 1; ext_alt_fn = 1; ext_dir_in = 1;
            ext_wake_en = 1; irq = i[0]; dma_done = ~i[0]; isr_done = 1; sleep_on_exit = 1;
            sleep_req = 1; sleep_target = 3'd0; step("R6");
        end
        do_reset();
        go_sleep(3'd6, "R3");
        for (int i = 0; i < 4; i++) begin
            dma_req = 4'b1111; wake_en = '1; irq = 1; isr_done = 1; step("R6");
        end
        do_reset();
        // Randomised run
        for (int i = 0; i < 2000; i++) begin
            if (i % 60 == 59) do_reset();
            dma_req       = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
            wake_en       = NCH'($urandom);
            ext_trig      = ($urandom % 5 == 0);
            ext_alt_fn    = ($urandom % 3 != 0);
            ext_dir_in    = ($urandom % 3 != 0);
            ext_wake_en   = $urandom % 2;
            dma_done      = ($urandom % 8 == 0);
            irq           = ($urandom % 10 == 0);
            sleep_req     = ($urandom % 4 == 0);
            sleep_target  = 3'($urandom);
            sleep_on_exit = $urandom % 2;
            isr_done      = ($urandom % 4 == 0);
            step("R2");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule